// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block sits beside the load/store unit of a single processor and decides, cycle by cycle, whether a conditional store may reach memory. The processor presents one request per cycle on a small port: a valid strobe, a two-bit operation code and an address. A separate pulse tells the block that an exception is being entered or left. The block answers with a write-enable that gates the memory write in the same cycle as the request. One cycle later it returns a completion strobe and a pass/fail bit for every conditional store.

Internally the block holds one reservation: a state bit, either Open or Reserved, and one tag. The tag is the request address with its low `GRAN_LOG2` bits cleared, so the reservation covers one aligned granule of 2^`GRAN_LOG2` bytes. The default granule is 8 bytes, and `GRAN_LOG2` must stay at 11 or below. A reserving load sets the reservation. A conditional store that finds a live reservation on its own granule writes and reports success. Every other conditional store is refused. Conditional stores, clear commands, exception pulses and plain stores that land on the reserved granule all drop the reservation.

Top module: `resv_monitor`

## Requirements
- R1: After reset the monitor is Open, `stxDone` and `stxFail` are 0, and a first conditional store is refused (no write, fail = 1).
- R2: A valid request with `reqOp` = 2'd0 (reserving load) makes the monitor Reserved and records the granule of `reqAddr`. A reserving load issued while already Reserved replaces the recorded granule and stays Reserved. It never asserts `memWrEn`.
- R3: A conditional store (`reqOp` = 2'd1) issued while Reserved to the recorded granule does three things: it asserts `memWrEn` in its own cycle, it reports fail = 0, and it leaves the monitor Open. A second conditional store with no reserving load in between is therefore refused.
- R4: A conditional store issued while Open does not assert `memWrEn`, reports fail = 1 and leaves the monitor Open.
- R5: A conditional store issued while Reserved to a different granule does not assert `memWrEn`, reports fail = 1 and leaves the monitor Open.
- R6: A plain store (`reqOp` = 2'd2) always asserts `memWrEn`. When its address lies outside the recorded granule it leaves the state and the recorded granule unchanged.
- R7: A plain store to the recorded granule while Reserved drops the monitor to Open.
- R8: A clear command (`reqOp` = 2'd3) and an `excPulse` both force the monitor Open. A clear command never asserts `memWrEn`. When `excPulse` coincides with a request, the pulse acts first: a reserving load in that cycle leaves the monitor Open, and a conditional store in that cycle is refused.
- R9: `stxDone` is 1 in exactly the cycle after a valid conditional store request and 0 otherwise. `stxFail` carries that store's result in the same cycle. Requests with `reqValid` = 0 have no effect.
- R10: Addresses that differ only in bits [`GRAN_LOG2`-1:0] belong to the same granule. With the default of 3, 0x0100 and 0x0107 match, while 0x0108 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqOp | input | 2 | 0 reserving load, 1 conditional store, 2 plain store, 3 clear |
| reqAddr | input | ADDR_W | Byte address of the request |
| excPulse | input | 1 | Exception entry or exit this cycle |
| memWrEn | output | 1 | Combinational enable for this cycle's memory write |
| stxDone | output | 1 | A conditional store completed in the previous cycle |
| stxFail | output | 1 | Result of that store: 1 refused, 0 written |

## Verification
The bench builds the block with `ADDR_W` = 16 and the default `GRAN_LOG2` = 3. With these values, short hand-written addresses can sit in the same granule, in a neighbouring granule one byte past the boundary, or far apart. That brings within reach the low-bit masking, the one-granule misses at 0x0108 and the retag from one granule to the next. The vector walk also covers the interactions between states: a pulse that coincides with a reserving load or a conditional store, back-to-back conditional stores, and an invalid request that carries a conditional-store code.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    OP_LDX = 2'd0,
    OP_STX = 2'd1,
    OP_ST  = 2'd2,
    OP_CLR = 2'd3
  } resvOp_t;

  typedef enum logic {
    ST_OPEN = 1'b0,
    ST_RESV = 1'b1
  } resvState_t;

  // Strobes from control to the tag datapath
  typedef struct packed {
    logic loadTag;
  } resvStrobe_t;

endpackage

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  resvStrobe_t       strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              tagHit
);

  localparam logic [ADDR_W-1:0] GRAN_MASK = {ADDR_W{1'b1}} << GRAN_LOG2;

  logic [ADDR_W-1:0] tagQ;
  logic [ADDR_W-1:0] reqGran;

  assign reqGran = reqAddr & GRAN_MASK;
  assign tagHit  = (reqGran == tagQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tagQ <= '0;
    end else if (strobe.loadTag) begin
      tagQ <= reqGran;
    end
  end

  // R2: the recorded granule only changes on a reserving load
  p_tag_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadTag |=> $stable(tagQ));

  // R10: right after a load, the same address hits
  p_load_hits_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadTag && rstN) ##1 $stable(reqAddr) |-> tagHit);

endmodule

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic        excPulse,
  input  logic        tagHit,
  output resvStrobe_t strobe,
  output logic        memWrEn,
  output logic        stxDone,
  output logic        stxFail
);

  resvState_t stateQ, stateD;
  logic isLdx, isStx, isSt, isClr;
  logic resvLive, stxPass;

  assign isLdx = reqValid && (reqOp == OP_LDX);
  assign isStx = reqValid && (reqOp == OP_STX);
  assign isSt  = reqValid && (reqOp == OP_ST);
  assign isClr = reqValid && (reqOp == OP_CLR);

  // An exception in the same cycle acts before the request
  assign resvLive = (stateQ == ST_RESV) && !excPulse;
  assign stxPass  = isStx && resvLive && tagHit;

  assign memWrEn        = isSt || stxPass;
  assign strobe.loadTag = isLdx && !excPulse;

  always_comb begin
    stateD = stateQ;
    if (excPulse || isClr || isStx) begin
      stateD = ST_OPEN;
    end else if (isLdx) begin
      stateD = ST_RESV;
    end else if (isSt && tagHit) begin
      stateD = ST_OPEN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_OPEN;
      stxDone <= 1'b0;
      stxFail <= 1'b0;
    end else begin
      stateQ  <= stateD;
      stxDone <= isStx;
      stxFail <= isStx && !stxPass;
    end
  end

  // R2
  p_ldx_reserves_r2: assert property (@(posedge clk) disable iff (!rstN)
    isLdx && !excPulse |=> stateQ == ST_RESV);
  // R3
  p_stx_drops_r3: assert property (@(posedge clk) disable iff (!rstN)
    isStx |=> stateQ == ST_OPEN);
  p_stx_write_ok_r3: assert property (@(posedge clk) disable iff (!rstN)
    isStx && memWrEn |=> stxDone && !stxFail);
  // R4
  p_open_stx_fails_r4: assert property (@(posedge clk) disable iff (!rstN)
    isStx && stateQ == ST_OPEN |=> stxFail);
  // R5
  p_miss_stx_fails_r5: assert property (@(posedge clk) disable iff (!rstN)
    isStx && !tagHit |=> stxFail);
  // R6
  p_st_miss_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    isSt && !tagHit && !excPulse |=> stateQ == $past(stateQ));
  // R8
  p_forced_open_r8: assert property (@(posedge clk) disable iff (!rstN)
    excPulse || isClr |=> stateQ == ST_OPEN);
  // R9
  p_fail_needs_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    stxFail |-> stxDone);

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              excPulse,
  output logic              memWrEn,
  output logic              stxDone,
  output logic              stxFail
);

  resvStrobe_t strobe;
  logic        tagHit;

  resv_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .excPulse (excPulse),
    .tagHit   (tagHit),
    .strobe   (strobe),
    .memWrEn  (memWrEn),
    .stxDone  (stxDone),
    .stxFail  (stxFail)
  );

  resv_datapath #(
    .ADDR_W    (ADDR_W),
    .GRAN_LOG2 (GRAN_LOG2)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .tagHit  (tagHit)
  );

endmodule

// File: tb/resv_monitor_tb.sv
`timescale 1ns/1ps
module resv_monitor_tb_top;

  localparam int AW = 16;
  localparam logic [1:0] LX = 2'd0, SX = 2'd1, ST = 2'd2, CL = 2'd3;
  localparam int NV = 29;

  // {req[3:0], valid, op[1:0], addr[15:0], exc, expWr, expDone, expFail}
  localparam logic [26:0] VEC [NV] = '{
    {4'd1, 1'b1, SX, 16'h0100, 1'b0, 1'b0, 1'b1, 1'b1}, // R1 first stx after reset
    {4'd2, 1'b1, LX, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd10,1'b1, SX, 16'h0105, 1'b0, 1'b1, 1'b1, 1'b0}, // R10 R3 same granule
    {4'd3, 1'b1, SX, 16'h0100, 1'b0, 1'b0, 1'b1, 1'b1}, // R3 second stx refused
    {4'd2, 1'b1, LX, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd6, 1'b1, ST, 16'h0108, 1'b0, 1'b1, 1'b0, 1'b0}, // R6 store outside
    {4'd6, 1'b1, SX, 16'h0100, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 reservation kept
    {4'd2, 1'b1, LX, 16'h0100, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd2, 1'b1, LX, 16'h0108, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 retag
    {4'd5, 1'b1, SX, 16'h0100, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 mismatch
    {4'd5, 1'b1, SX, 16'h0108, 1'b0, 1'b0, 1'b1, 1'b1}, // R5 left open
    {4'd2, 1'b1, LX, 16'h0200, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd7, 1'b1, ST, 16'h0207, 1'b0, 1'b1, 1'b0, 1'b0}, // R7 store hits granule
    {4'd7, 1'b1, SX, 16'h0200, 1'b0, 1'b0, 1'b1, 1'b1}, // R7 dropped
    {4'd2, 1'b1, LX, 16'h0200, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd8, 1'b1, CL, 16'h0200, 1'b0, 1'b0, 1'b0, 1'b0}, // R8 clear
    {4'd8, 1'b1, SX, 16'h0200, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd2, 1'b1, LX, 16'h0300, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd8, 1'b0, LX, 16'h0300, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 bare pulse
    {4'd8, 1'b1, SX, 16'h0300, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd8, 1'b1, LX, 16'h0300, 1'b1, 1'b0, 1'b0, 1'b0}, // R8 pulse with load
    {4'd8, 1'b1, SX, 16'h0300, 1'b0, 1'b0, 1'b1, 1'b1},
    {4'd2, 1'b1, LX, 16'h0300, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd8, 1'b1, SX, 16'h0300, 1'b1, 1'b0, 1'b1, 1'b1}, // R8 pulse with stx
    {4'd2, 1'b1, LX, 16'h0400, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd9, 1'b0, SX, 16'h0400, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 invalid ignored
    {4'd9, 1'b1, SX, 16'h0400, 1'b0, 1'b1, 1'b1, 1'b0},
    {4'd10,1'b1, LX, 16'h0408, 1'b0, 1'b0, 1'b0, 1'b0},
    {4'd10,1'b1, SX, 16'h040F, 1'b0, 1'b1, 1'b1, 1'b0}  // R10 top of granule
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqOp = 2'd0;
  logic [AW-1:0] reqAddr = '0;
  logic          excPulse = 1'b0;
  logic          memWrEn, stxDone, stxFail;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  resv_monitor #(.ADDR_W(AW), .GRAN_LOG2(3)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .excPulse(excPulse),
    .memWrEn(memWrEn), .stxDone(stxDone), .stxFail(stxFail)
  );

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [1:0] op,
                       input logic [AW-1:0] a, input logic e);
    @(negedge clk);
    reqValid = v; reqOp = op; reqAddr = a; excPulse = e;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1", "stxDone in reset", stxDone, 1'b0);
    check("R1", "stxFail in reset", stxFail, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[26:23], i);
      drive(v[22], v[21:20], v[19:4], v[3]);
      #1;
      check(tag, "memWrEn", memWrEn, v[2]);
      @(posedge clk);
      #1;
      check(tag, "stxDone", stxDone, v[1]);
      check(tag, "stxFail", stxFail, v[0]);
    end

    // R1: reset in the middle of a reservation drops it
    drive(1'b1, LX, 16'h0500, 1'b0);
    drive(1'b0, LX, 16'h0500, 1'b0);
    rstN = 1'b0;
    @(posedge clk); #1;
    check("R1", "stxDone after mid reset", stxDone, 1'b0);
    drive(1'b0, LX, 16'h0500, 1'b0);
    rstN = 1'b1;
    drive(1'b1, SX, 16'h0500, 1'b0);
    #1;
    check("R1", "memWrEn stx after mid reset", memWrEn, 1'b0);
    @(posedge clk); #1;
    check("R1", "stxFail after mid reset", stxFail, 1'b1);

    // R9: done lasts a single cycle
    drive(1'b0, ST, 16'h0000, 1'b0);
    @(posedge clk); #1;
    check("R9", "stxDone falls", stxDone, 1'b0);

    // R6/R8: plain store writes and clear does not, any state
    drive(1'b1, ST, 16'hFFF8, 1'b0);
    #1;
    check("R6", "plain store write", memWrEn, 1'b1);
    drive(1'b1, CL, 16'hFFF8, 1'b0);
    #1;
    check("R8", "clear no write", memWrEn, 1'b0);
    drive(1'b0, LX, 16'h0000, 1'b0);
    @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule